// File: doc/BRIEF.md
# Round-Robin Single-Word Memory Job Arbiter

This block lets three requesters share one external memory port. A requester posts a job: one word, either read or write, at a 9-bit offset. The arbiter chooses one pending requester in rotating order and acknowledges its job. It then grants that requester either the write buffer, where the requester pushes one word, or the read buffer, where the requester pops the word that came back. A transfer of several words takes one job per word.

The memory address is the sum of a base register and the zero-extended offset, taken modulo the 19-bit address space. The host loads the base register. Inside the block, a simple word store stands in for the memory controller. A write word leaves the write buffer a fixed number of cycles after it is pushed. Read data reaches the read buffer the same fixed number of cycles after the acknowledge. Only one job is in flight at any time.

Top module: `memjob_rr_arb`

## Requirements
- R1: During reset and just after it, no acknowledge and no grant is asserted, the read buffer reports empty and the write buffer reports not full. If all three requesters post at once after reset, requester 0 is served first.
- R2: When several requesters are pending, service rotates. The next search starts at the requester after the last one whose push or pop completed, so three requesters that keep posting are served 0, 1, 2, 0, 1, 2.
- R3: The cycle after a job is accepted, the arbiter raises job_ack for the winner only, for exactly one cycle. Bit i of every per-requester vector belongs to requester i.
- R4: After acknowledging a write (job_rd=0), the arbiter holds wr_grant to the winner until that requester asserts push_req. From the cycle after the push, wr_fifo_full stays high for LAT cycles. The pushed word is then stored.
- R5: After acknowledging a read (job_rd=1), the arbiter waits LAT cycles. Then rd_fifo_empty drops, and rd_grant to the winner is held until that requester asserts pop_req. While rd_grant is high, pop_data holds the word last written at that address. rd_fifo_empty returns high the cycle after the pop.
- R6: An accepted job's address equals (base + offset[8:0]) mod 2^19. mem_addr shows it from the acknowledge cycle until the job completes. The word store is indexed by the address's low log2(MEM_WORDS) bits.
- R7: A base_we pulse takes effect on the next cycle. A job accepted in the same cycle as the base write uses the old base.
- R8: If a requester drops job_issue before it is acknowledged, it gets no acknowledge and no grant. The search then moves on to the next requester.
- R9: Only one job is in flight. No acknowledge is given while a grant is held or the write buffer is full, and at most one grant is asserted at a time.
- R10: push_req and pop_req from a requester that holds no grant are ignored. Stored data and buffer state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the base register |
| base_wdata | input | AW | New base address |
| job_issue | input | N_REQ | Job request, one bit per requester |
| job_rd | input | N_REQ | Job direction: 1 read, 0 write |
| job_off | input | N_REQ*OFFW | Word offset per requester, requester i at bits [i*OFFW +: OFFW] |
| push_data | input | N_REQ*DW | Write word per requester, requester i at bits [i*DW +: DW] |
| push_req | input | N_REQ | Push one word into the write buffer |
| pop_req | input | N_REQ | Pop one word from the read buffer |
| job_ack | output | N_REQ | Job accepted |
| wr_grant | output | N_REQ | Write buffer granted |
| rd_grant | output | N_REQ | Read buffer granted |
| pop_data | output | DW | Read buffer word |
| rd_fifo_empty | output | 1 | Read buffer empty |
| wr_fifo_full | output | 1 | Write buffer full |
| mem_addr | output | AW | Address of the current job |

## Verification
Two functions can land in the same cycle. The first is a base-register write arriving in the very cycle the arbiter accepts a job. The bench triggers it by pulsing base_we and raising a requester's job_issue together while the arbiter is idle. The acknowledged address must carry the old base, and the next job must carry the new base, including its wrap past the top of the 19-bit space. The second is a requester dropping its request in the cycle where the acknowledge would have come. The bench triggers it with two requesters posting together and the first withdrawing. It judges the result from the missing acknowledge and from the order of the service that follows.

// File: rtl/memjob_rr_arb.sv
module memjob_rr_arb #(
  parameter int N_REQ     = 3,
  parameter int DW        = 32,
  parameter int AW        = 19,
  parameter int OFFW      = 9,
  parameter int MEM_WORDS = 512,
  parameter int LAT       = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  base_we,
  input  logic [AW-1:0]         base_wdata,
  input  logic [N_REQ-1:0]      job_issue,
  input  logic [N_REQ-1:0]      job_rd,
  input  logic [N_REQ*OFFW-1:0] job_off,
  input  logic [N_REQ*DW-1:0]   push_data,
  input  logic [N_REQ-1:0]      push_req,
  input  logic [N_REQ-1:0]      pop_req,
  output logic [N_REQ-1:0]      job_ack,
  output logic [N_REQ-1:0]      wr_grant,
  output logic [N_REQ-1:0]      rd_grant,
  output logic [DW-1:0]         pop_data,
  output logic                  rd_fifo_empty,
  output logic                  wr_fifo_full,
  output logic [AW-1:0]         mem_addr
);
  localparam int SW = (N_REQ > 1) ? $clog2(N_REQ) : 1;
  localparam int MW = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;
  localparam int CW = $clog2(LAT + 1);

  typedef enum logic [2:0] {S_IDLE, S_ACK, S_WGNT, S_DRAIN, S_RWAIT, S_RGNT} st_t;

  st_t             st;
  logic [SW-1:0]   ptr, sel, win, nxt_ptr;
  logic            found, rd_q, full_q, empty_q;
  logic [AW-1:0]   base_q, addr_q;
  logic [DW-1:0]   wbuf, rbuf;
  logic [CW-1:0]   cnt;
  logic [DW-1:0]   mem [MEM_WORDS];
  logic [N_REQ-1:0] sel_oh;
  logic            cnt_done, commit;

  always_comb begin
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N_REQ; k++) begin
      int idx;
      idx = int'(ptr) + k;
      if (idx >= N_REQ) idx = idx - N_REQ;
      if (!found && job_issue[idx]) begin
        found = 1'b1;
        win   = SW'(idx);
      end
    end
  end

  assign nxt_ptr  = (int'(sel) == N_REQ - 1) ? '0 : sel + 1'b1;
  assign sel_oh   = N_REQ'(1) << sel;
  assign cnt_done = (cnt == CW'(LAT - 1));
  assign commit   = (st == S_DRAIN) && cnt_done;

  assign job_ack       = (st == S_ACK && job_issue[sel]) ? sel_oh : '0;
  assign wr_grant      = (st == S_WGNT) ? sel_oh : '0;
  assign rd_grant      = (st == S_RGNT) ? sel_oh : '0;
  assign pop_data      = rbuf;
  assign rd_fifo_empty = empty_q;
  assign wr_fifo_full  = full_q;
  assign mem_addr      = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ptr     <= '0;
      sel     <= '0;
      rd_q    <= 1'b0;
      base_q  <= '0;
      addr_q  <= '0;
      wbuf    <= '0;
      rbuf    <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      cnt     <= '0;
    end else begin
      if (base_we) base_q <= base_wdata;
      case (st)
        S_IDLE: if (found) begin
          sel    <= win;
          rd_q   <= job_rd[win];
          addr_q <= base_q + AW'(job_off[int'(win)*OFFW +: OFFW]);
          st     <= S_ACK;
        end
        S_ACK: begin
          cnt <= '0;
          if (job_issue[sel]) st <= rd_q ? S_RWAIT : S_WGNT;
          else begin
            ptr <= nxt_ptr;
            st  <= S_IDLE;
          end
        end
        S_WGNT: if (push_req[sel]) begin
          wbuf   <= push_data[int'(sel)*DW +: DW];
          full_q <= 1'b1;
          cnt    <= '0;
          ptr    <= nxt_ptr;
          st     <= S_DRAIN;
        end
        S_DRAIN: begin
          if (cnt_done) begin
            full_q <= 1'b0;
            st     <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        S_RWAIT: begin
          if (cnt_done) begin
            rbuf    <= mem[addr_q[MW-1:0]];
            empty_q <= 1'b0;
            st      <= S_RGNT;
          end else cnt <= cnt + 1'b1;
        end
        S_RGNT: if (pop_req[sel]) begin
          empty_q <= 1'b1;
          ptr     <= nxt_ptr;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[addr_q[MW-1:0]] <= wbuf;
  end
endmodule

// File: rtl/memjob_rr_arb_chk.sv
module memjob_rr_arb_chk #(
  parameter int N_REQ = 3,
  parameter int AW    = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] job_issue,
  input logic [N_REQ-1:0] push_req,
  input logic [N_REQ-1:0] pop_req,
  input logic [N_REQ-1:0] job_ack,
  input logic [N_REQ-1:0] wr_grant,
  input logic [N_REQ-1:0] rd_grant,
  input logic             rd_fifo_empty,
  input logic             wr_fifo_full,
  input logic [AW-1:0]    mem_addr
);
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(job_ack)); // R3
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) (|job_ack) |=> (job_ack == '0)); // R3
  AST_ACK_NEEDS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n) (|job_ack) |-> ((job_ack & job_issue) == job_ack)); // R8
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({wr_grant, rd_grant})); // R9
  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (wr_fifo_full || (|wr_grant) || (|rd_grant)) |-> (job_ack == '0)); // R9
  AST_WR_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) ((|wr_grant) && ((wr_grant & push_req) == '0)) |=> (wr_grant == $past(wr_grant))); // R4
  AST_FULL_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (|(wr_grant & push_req)) |=> wr_fifo_full); // R4
  AST_RD_GRANT_READY: assert property (@(posedge clk) disable iff (!rst_n) (|rd_grant) |-> !rd_fifo_empty); // R5
  AST_POP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (|(rd_grant & pop_req)) |=> rd_fifo_empty); // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (|(wr_grant | rd_grant)) |-> $stable(mem_addr)); // R6
endmodule

bind memjob_rr_arb memjob_rr_arb_chk #(.N_REQ(N_REQ), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .job_issue(job_issue), .push_req(push_req),
  .pop_req(pop_req), .job_ack(job_ack), .wr_grant(wr_grant), .rd_grant(rd_grant),
  .rd_fifo_empty(rd_fifo_empty), .wr_fifo_full(wr_fifo_full), .mem_addr(mem_addr)
);

// File: tb/memjob_rr_arb_tb_top.sv
`timescale 1ns/1ps
module memjob_rr_arb_tb_top;
  localparam int N = 3, DW = 32, AW = 19, OFFW = 9, LAT = 3, MWORDS = 512;

  typedef struct {
    bit          rd;
    bit          abort;
    int          off;
    logic [31:0] d;
  } job_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n = 1'b0;
  logic            base_we = 1'b0;
  logic [AW-1:0]   base_wdata = '0;
  logic [N-1:0]    issue = '0, rdb = '0, push = '0, pop = '0;
  logic [N*OFFW-1:0] off = '0;
  logic [N*DW-1:0] pdata = '0;
  logic [N-1:0]    job_ack, wr_grant, rd_grant;
  logic [DW-1:0]   pop_data;
  logic            rd_fifo_empty, wr_fifo_full;
  logic [AW-1:0]   mem_addr;

  memjob_rr_arb dut_i (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .job_issue(issue), .job_rd(rdb), .job_off(off), .push_data(pdata),
    .push_req(push), .pop_req(pop), .job_ack(job_ack), .wr_grant(wr_grant),
    .rd_grant(rd_grant), .pop_data(pop_data), .rd_fifo_empty(rd_fifo_empty),
    .wr_fifo_full(wr_fifo_full), .mem_addr(mem_addr)
  );

  int checks = 0, errors = 0;
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // requester agents
  job_t jq[N][$];
  bit   pend[N], abortj[N], stray_push[N], stray_pop[N];
  bit   base_req = 0;
  logic [AW-1:0] base_val;
  logic [N-1:0] s_ack = '0, s_wg = '0, s_rg = '0;
  logic [DW-1:0] s_pdata;
  int log_id[$];
  logic [31:0] log_data[$];
  logic [AW-1:0] ack_addr[$];
  int ack0_cnt = 0;

  always @(posedge clk) begin
    #1;
    base_we = base_req;
    if (base_req) begin base_wdata = base_val; base_req = 0; end
    for (int i = 0; i < N; i++) begin
      push[i] = stray_push[i];
      pop[i]  = stray_pop[i];
      if (pend[i]) begin
        if (abortj[i]) begin
          issue[i] = 1'b0; pend[i] = 0;
        end else begin
          if (s_ack[i]) issue[i] = 1'b0;
          if (s_wg[i]) begin push[i] = 1'b1; pend[i] = 0; log_id.push_back(i); log_data.push_back(pdata[i*DW +: DW]); end
          if (s_rg[i]) begin pop[i] = 1'b1; pend[i] = 0; log_id.push_back(i); log_data.push_back(s_pdata); end
        end
      end else if (jq[i].size() > 0) begin
        job_t j;
        j = jq[i].pop_front();
        issue[i] = 1'b1;
        rdb[i]   = j.rd;
        off[i*OFFW +: OFFW] = OFFW'(j.off);
        pdata[i*DW +: DW]   = j.d;
        abortj[i] = j.abort;
        pend[i] = 1;
      end
    end
  end

  // behavioural reference, stepped on every rising edge
  int ph = 0, msel = 0, mptr = 0, mcnt = 0;
  bit mrd = 0, mfull = 0, mempty = 1, live = 0;
  logic [AW-1:0] maddr = '0, mbase = '0, nb;
  logic [DW-1:0] mwbuf = '0, mrbuf = '0;
  logic [DW-1:0] mmem[int];

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; msel = 0; mptr = 0; mcnt = 0; mrd = 0; mfull = 0; mempty = 1;
      maddr = '0; mbase = '0; mrbuf = '0; live = 0;
    end else begin
      live = 1;
      nb = base_we ? base_wdata : mbase;
      case (ph)
        0: for (int k = 0; k < N; k++) begin
             int c;
             c = (mptr + k) % N;
             if (ph == 0 && issue[c]) begin
               msel = c; mrd = rdb[c];
               maddr = AW'(mbase + AW'(off[c*OFFW +: OFFW]));
               ph = 1;
             end
           end
        1: begin
             mcnt = 0;
             if (issue[msel]) ph = mrd ? 4 : 2;
             else begin mptr = (msel + 1) % N; ph = 0; end
           end
        2: if (push[msel]) begin
             mwbuf = pdata[msel*DW +: DW]; mfull = 1; mcnt = 0;
             mptr = (msel + 1) % N; ph = 3;
           end
        3: if (mcnt == LAT - 1) begin
             mmem[int'(maddr) % MWORDS] = mwbuf; mfull = 0; ph = 0;
           end else mcnt++;
        4: if (mcnt == LAT - 1) begin
             mrbuf = mmem.exists(int'(maddr) % MWORDS) ? mmem[int'(maddr) % MWORDS] : '0;
             mempty = 0; ph = 5;
           end else mcnt++;
        5: if (pop[msel]) begin
             mempty = 1; mptr = (msel + 1) % N; ph = 0;
           end
        default: ph = 0;
      endcase
      mbase = nb;
    end
  end

  int frun = 0;
  always @(negedge clk) begin
    logic [N-1:0] e_ack, e_wg, e_rg;
    s_ack = job_ack; s_wg = wr_grant; s_rg = rd_grant; s_pdata = pop_data;
    if (|job_ack) ack_addr.push_back(mem_addr);
    if (job_ack[0]) ack0_cnt++;
    if (live) begin
      e_ack = (ph == 1 && issue[msel]) ? N'(1 << msel) : '0;
      e_wg  = (ph == 2) ? N'(1 << msel) : '0;
      e_rg  = (ph == 5) ? N'(1 << msel) : '0;
      chk("R3 job_ack", job_ack, e_ack);
      chk("R9 wr_grant", wr_grant, e_wg);
      chk("R9 rd_grant", rd_grant, e_rg);
      chk("R5 rd_fifo_empty", rd_fifo_empty, mempty);
      chk("R4 wr_fifo_full", wr_fifo_full, mfull);
      chk("R6 mem_addr", mem_addr, maddr);
      if (!mempty) chk("R5 pop_data", pop_data, mrbuf);
      if (wr_fifo_full) frun++;
      else if (frun != 0) begin chk("R4 full length", frun, LAT); frun = 0; end
    end
  end

  task automatic put(int r, bit rd, int o, logic [31:0] d, bit ab);
    job_t j;
    j.rd = rd; j.off = o; j.d = d; j.abort = ab;
    jq[r].push_back(j);
  endtask

  task automatic wait_log(int n);
    for (int t = 0; t < 3000 && log_id.size() < n; t++) @(negedge clk);
  endtask

  task automatic wait_quiet();
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (jq[0].size() == 0 && jq[1].size() == 0 && jq[2].size() == 0 &&
          !pend[0] && !pend[1] && !pend[2] && ph == 0 && !mfull && issue == '0) break;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R9 actual=hang expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0, n0;
    repeat (2) @(negedge clk);
    chk("R1 ack in reset", job_ack, 0);
    chk("R1 grants in reset", {wr_grant, rd_grant}, 0);
    chk("R1 empty in reset", rd_fifo_empty, 1);
    chk("R1 full in reset", wr_fifo_full, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R1/R2: everyone posts two writes at once
    @(negedge clk);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < 2; j++) put(i, 0, 16 + i*2 + j, 32'h1000_0000 + i*16 + j, 0);
    wait_log(6);
    chk("R1 first served", log_id[0], 0);
    for (int k = 1; k < 6; k++) chk("R2 rotation order", log_id[k], k % N);

    // R5/R10: read back while requester 0 pushes and pops without a grant
    wait_quiet();
    stray_push[0] = 1; stray_pop[0] = 1;
    put(1, 1, 16, 0, 0);
    put(2, 1, 21, 0, 0);
    wait_log(8);
    chk("R5 read order", log_id[6], 1);
    chk("R5 R10 read data req1", log_data[6], 32'h1000_0000);
    chk("R5 R10 read data req2", log_data[7], 32'h1000_0021);
    wait_quiet();
    stray_push[0] = 0; stray_pop[0] = 0;

    // R7/R6: base write in the acceptance cycle, then wrap
    wait_quiet();
    a0 = ack_addr.size();
    base_req = 1; base_val = 19'h7FFF0;
    put(2, 0, 9'h1FF, 32'hAAAA_0001, 0);
    wait_log(9);
    chk("R7 old base used", ack_addr[a0], 19'h001FF);
    put(2, 0, 9'h1FF, 32'hBBBB_0002, 0);
    wait_log(10);
    chk("R6 wrapped address", ack_addr[a0+1], 19'h001EF);
    put(2, 1, 9'h1FF, 0, 0);
    wait_log(11);
    chk("R6 read at wrapped address", log_data[10], 32'hBBBB_0002);

    // R8: requester 0 withdraws before its acknowledge
    wait_quiet();
    n0 = ack0_cnt;
    put(0, 0, 3, 32'hDEAD_0000, 1);
    put(1, 0, 3, 32'h0000_1111, 0);
    wait_log(12);
    chk("R8 no ack to withdrawn requester", ack0_cnt, n0);
    chk("R8 next requester served", log_id[11], 1);
    wait_quiet();
    put(0, 0, 4, 32'h0000_2222, 0);
    put(2, 0, 5, 32'h0000_3333, 0);
    wait_log(14);
    chk("R8 R2 pointer past requester 1", log_id[12], 2);
    chk("R8 R2 then requester 0", log_id[13], 0);
    wait_quiet();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule